// File: doc/BRIEF.md
# One-Shot Countdown Timer for a Local Interrupt Controller

This block is the timer of a per-core interrupt controller. Software loads a 32-bit start value and a divide setting; the timer then counts down once and signals completion. One timer tick lasts a fixed sixteen core cycles multiplied by a power-of-two divisor taken from the divide setting. There is no decrementing register. The block keeps a free-running core-cycle counter. When a start value is loaded, the block stores the absolute cycle at which the countdown ends. The remaining tick count is worked out on each read from the gap between that end cycle and the present cycle.

Writes go through one port with a 2-bit register select. Reads return registered data one cycle after the select is sampled. When the end cycle is reached, the `expire` output pulses high for a single cycle. Loading zero cancels a countdown that is running. The divisor is captured when the start value is loaded, so a later change to the divide setting does not affect the countdown already running.

Top module: `irq_countdown_timer`

## Requirements
- R1: A write with select 1 (divide setting) keeps only bits 3, 1 and 0 of the data (mask 0xB) and clears every other bit. A read with select 1 returns the stored value in bits 3:0, with zeros above.
- R2: The divide code is {bit 3, bit 1, bit 0} of the divide setting, with bit 3 as the most significant bit. The divisor is 2^((code+1) mod 8). Code 7 (setting 0xB) gives 1, code 0 gives 2, code 4 (0x8) gives 32 and code 6 (0xA) gives 128.
- R3: A write with select 0 stores the 32-bit start value, which a read with select 0 returns. If the write is sampled at core cycle N, the end cycle is N + value × 16 × divisor.
- R4: A read with select 2 sampled at cycle M returns floor((end − M) / (16 × divisor)) on `rd_data` after the next clock edge.
- R5: Writes with select 2 (current count) or select 3 are ignored, and no register or countdown changes. A read with select 3 returns zero.
- R6: Once the core-cycle counter reaches the end cycle, the current count reads zero. `expire` is high for exactly one cycle: the cycle in which the counter equals the end cycle.
- R7: Loading a start value of zero stops the timer. The current count reads zero and `expire` does not fire for the countdown that was cancelled. A new load also replaces a running countdown without expiring it.
- R8: The divisor used by a countdown is the one in force when the start value was written. A later divide-setting write leaves the current-count reads and the expiry cycle of that countdown unchanged.
- R9: After reset the start value, the divide setting and the current count all read zero, and `expire` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the timebase |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select: 0 start value, 1 divide setting, 2 current count (ignored), 3 reserved (ignored) |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read register select, same encoding as `wr_sel` |
| rd_data | output | DATA_W | Registered read data, valid one cycle after `rd_sel` is sampled |
| expire | output | 1 | Single-cycle pulse when the countdown reaches its end cycle |

## Verification
The state inside the block is a stored end cycle, a captured divisor and an armed flag. An error in any of them shows at the ports in a known way. A wrong end cycle or captured divisor changes the very next current-count read, or moves the `expire` pulse by at least one cycle. A stale armed flag gives an extra pulse or drops the expected one at the end cycle. The bench keeps its own copy of the cycle counter. Every cycle it compares both `rd_data` and `expire`, so a fault shows within one cycle of the read or the end cycle that exposes it.

// File: rtl/ict_pkg.sv
package ict_pkg;

  // Register select encoding shared by the write and read ports.
  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  // Bits of the divide setting that are stored on a write.
  localparam logic [3:0] DIV_KEEP_MASK = 4'hB;

  // Turn a divide setting into log2 of the divisor: code {b3,b1,b0}, plus one, modulo 8.
  function automatic logic [2:0] div_log2(input logic [3:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/ict_cycle_base.sv
module ict_cycle_base #(
  parameter int CYC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CYC_W-1:0] now_o
);

  logic [CYC_W-1:0] now_q;

  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + CYC_W'(1);
  end

  assign now_o = now_q;

endmodule

// File: rtl/ict_div_cfg.sv
module ict_div_cfg (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [3:0] wdata,
  output logic [3:0] cfg_o,
  output logic [2:0] log2_o
);
  import ict_pkg::*;

  logic [3:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata & DIV_KEEP_MASK;
  end

  assign cfg_o  = cfg_q;
  assign log2_o = div_log2(cfg_q);

  AST_DIV_STORED_BITS: assert property (@(posedge clk) disable iff (rst)
    we |=> (cfg_o[2] == 1'b0) && (cfg_o[3] == $past(wdata[3])) && (cfg_o[1:0] == $past(wdata[1:0]))); // R1

endmodule

// File: rtl/ict_deadline.sv
module ict_deadline #(
  parameter int DATA_W   = 32,
  parameter int CYC_W    = 64,
  parameter int PRE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [2:0]        log2_in,
  input  logic [CYC_W-1:0]  now,
  output logic [DATA_W-1:0] remain_o,
  output logic              expire_o
);

  localparam int TSH_W = $clog2(7 + PRE_LOG2 + 1) + 1;

  logic [CYC_W-1:0] deadline_q;
  logic             armed_q;
  logic [2:0]       log2_q;
  logic             expire_q;

  logic [TSH_W-1:0] load_shift;
  logic [TSH_W-1:0] run_shift;
  logic [CYC_W-1:0] load_span;
  logic [CYC_W-1:0] gap;
  logic             passed;
  logic             hit;

  assign load_shift = TSH_W'(log2_in) + TSH_W'(PRE_LOG2);
  assign run_shift  = TSH_W'(log2_q)  + TSH_W'(PRE_LOG2);
  assign load_span  = CYC_W'(load_val) << load_shift;
  assign hit        = armed_q && ((now + CYC_W'(1)) == deadline_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      deadline_q <= '0;
      armed_q    <= 1'b0;
      log2_q     <= '0;
      expire_q   <= 1'b0;
    end else if (load) begin
      deadline_q <= now + load_span;
      armed_q    <= |load_val;
      log2_q     <= log2_in;
      expire_q   <= 1'b0;
    end else begin
      expire_q <= hit;
      if (hit) armed_q <= 1'b0;
    end
  end

  assign gap      = deadline_q - now;
  assign passed   = (now >= deadline_q);
  assign remain_o = passed ? '0 : DATA_W'(gap >> run_shift);
  assign expire_o = expire_q;

  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    expire_q |=> !expire_q); // R6
  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    expire_q |-> (remain_o == '0)); // R6
  AST_ZERO_LOAD_STOPS: assert property (@(posedge clk) disable iff (rst)
    (load && (load_val == '0)) |=> (!armed_q && !expire_q && (remain_o == '0))); // R7
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(log2_q)); // R8

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int DATA_W   = 32,
  parameter int CYC_W    = 64,
  parameter int PRE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              expire
);
  import ict_pkg::*;

  logic [CYC_W-1:0]  now;
  logic [3:0]        div_cfg;
  logic [2:0]        div_log2_w;
  logic [DATA_W-1:0] init_q;
  logic [DATA_W-1:0] remain;
  logic [DATA_W-1:0] rd_q;
  logic              wr_init;
  logic              wr_div;

  assign wr_init = wr_en && (wr_sel == SEL_INIT);
  assign wr_div  = wr_en && (wr_sel == SEL_DIV);

  ict_cycle_base #(.CYC_W(CYC_W)) u_base (
    .clk   (clk),
    .rst   (rst),
    .now_o (now)
  );

  ict_div_cfg u_div (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_div),
    .wdata  (wr_data[3:0]),
    .cfg_o  (div_cfg),
    .log2_o (div_log2_w)
  );

  ict_deadline #(.DATA_W(DATA_W), .CYC_W(CYC_W), .PRE_LOG2(PRE_LOG2)) u_dl (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_init),
    .load_val (wr_data),
    .log2_in  (div_log2_w),
    .now      (now),
    .remain_o (remain),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst)          init_q <= '0;
    else if (wr_init) init_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_sel)
        SEL_INIT: rd_q <= init_q;
        SEL_DIV:  rd_q <= DATA_W'(div_cfg);
        SEL_CUR:  rd_q <= remain;
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[1]) |=> ($stable(init_q) && $stable(div_cfg))); // R5
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_RSVD) |=> (rd_data == '0)); // R5

endmodule

// File: tb/irq_countdown_timer_tb_top.sv
module irq_countdown_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        expire;

  always #5 clk = ~clk;

  irq_countdown_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .expire(expire)
  );

  logic [63:0] tb_now;
  always @(posedge clk) begin
    if (rst) tb_now <= 64'd0;
    else     tb_now <= tb_now + 64'd1;
  end

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Model state
  logic [31:0] m_init = 0;
  logic [3:0]  m_cfg = 0;
  logic [63:0] m_dl = 0;
  bit          m_armed = 0;
  int          m_sh = 0;
  logic [31:0] exp_rd = 0;
  bit          exp_exp = 0;
  bit          exp_valid = 0;
  string       exp_tag = "R9";

  function automatic int div_log2_f(input logic [3:0] cfg);
    return ({cfg[3], cfg[1:0]} + 1) % 8;
  endfunction

  function automatic logic [31:0] remain_f(input logic [63:0] n);
    if (m_dl > n) return 32'((m_dl - n) >> (m_sh + 4));
    return 32'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, tb_now);
    end
  endtask

  task automatic step(input bit we, input logic [1:0] ws, input logic [31:0] wd,
                      input logic [1:0] rs, input string tag);
    logic [63:0] n;
    bit hit;
    @(negedge clk);
    if (exp_valid) chk(rd_data === exp_rd, exp_tag, 64'(rd_data), 64'(exp_rd));
    chk(expire === exp_exp, "R6 expire", 64'(expire), 64'(exp_exp));
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    n = tb_now;
    case (rs)
      2'd0: exp_rd = m_init;
      2'd1: exp_rd = {28'd0, m_cfg};
      2'd2: exp_rd = remain_f(n);
      default: exp_rd = 32'd0;
    endcase
    if (tag != "") exp_tag = tag;
    else exp_tag = (rs == 2'd0) ? "R3" : (rs == 2'd1) ? "R1" : (rs == 2'd2) ? "R4" : "R5";
    hit = m_armed && (m_dl == n + 64'd1);
    if (hit) m_armed = 0;
    exp_exp = hit && !(we && ws == 2'd0);
    if (we) begin
      case (ws)
        2'd0: begin
          m_init  = wd;
          m_sh    = div_log2_f(m_cfg);
          m_armed = (wd != 0);
          m_dl    = n + ({32'd0, wd} << (m_sh + 4));
        end
        2'd1: m_cfg = wd[3:0] & 4'hB;
        default: ;
      endcase
    end
    exp_valid = 1;
  endtask

  task automatic idle(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) step(0, 2'd0, 32'd0, 2'd2, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    exp_valid = 1; exp_rd = 0; exp_tag = "R9";
    step(0, 2'd0, 32'd0, 2'd1, "R9");
    step(0, 2'd0, 32'd0, 2'd2, "R9");
    step(0, 2'd0, 32'd0, 2'd0, "R9");
    // R1: mask
    step(1, 2'd1, 32'hFFFF_FFFF, 2'd1, "R1");
    step(0, 2'd0, 32'd0, 2'd1, "R1");
    step(1, 2'd1, 32'h0000_0004, 2'd1, "R1");
    step(0, 2'd0, 32'd0, 2'd1, "R1");
    // R2/R3: divide codes
    step(1, 2'd1, 32'hB, 2'd1, "R2");
    step(1, 2'd0, 32'd10, 2'd0, "R3");
    step(0, 2'd0, 32'd0, 2'd0, "R3");
    idle(170, "R2");
    step(1, 2'd1, 32'h0, 2'd1, "R2");
    step(1, 2'd0, 32'd3, 2'd2, "R2");
    idle(100, "R2");
    step(1, 2'd1, 32'h8, 2'd1, "R2");
    step(1, 2'd0, 32'd1, 2'd2, "R2");
    idle(520, "R2");
    step(1, 2'd1, 32'hA, 2'd1, "R2");
    step(1, 2'd0, 32'd2, 2'd2, "R2");
    idle(4100, "R2");
    // R5: read-only and reserved writes
    step(1, 2'd1, 32'hB, 2'd1, "R5");
    step(1, 2'd0, 32'd20, 2'd2, "R5");
    idle(10, "R5");
    step(1, 2'd2, 32'd0, 2'd2, "R5");
    step(1, 2'd3, 32'd123, 2'd0, "R5");
    step(0, 2'd0, 32'd0, 2'd3, "R5");
    idle(330, "R5");
    // R7: zero load cancels
    step(1, 2'd0, 32'd6, 2'd2, "R7");
    idle(20, "R7");
    step(1, 2'd0, 32'd0, 2'd2, "R7");
    idle(120, "R7");
    step(1, 2'd0, 32'd5, 2'd2, "R7");
    idle(30, "R7");
    step(1, 2'd0, 32'd2, 2'd2, "R7");
    idle(60, "R7");
    // R8: divisor latched at load
    step(1, 2'd1, 32'hB, 2'd1, "R8");
    step(1, 2'd0, 32'd4, 2'd2, "R8");
    step(1, 2'd1, 32'hA, 2'd2, "R8");
    idle(80, "R8");
    // Constrained random mix
    for (int k = 0; k < 5000; k++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 19);
      if (op == 0)      v = $urandom;
      else              v = $urandom_range(0, 24);
      if (op <= 1)      step(1, 2'd0, v, 2'($urandom_range(0, 3)), "");
      else if (op == 2) step(1, 2'd1, $urandom, 2'($urandom_range(0, 3)), "");
      else if (op == 3) step(1, 2'($urandom_range(2, 3)), $urandom, 2'($urandom_range(0, 3)), "");
      else              step(0, 2'd0, 32'd0, 2'($urandom_range(0, 3)), "");
    end
    step(0, 2'd0, 32'd0, 2'd2, "");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule